// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Strap-Selected Write Mode

This block is a 256-word by 9-bit first-in first-out buffer. The producer and the consumer each run on their own clock, and the two clocks may be unrelated or identical. Words enter on rising edges of the write clock. On a rising edge of the read clock, the next word moves into a registered output. Four active-low status flags report the fill state: full, almost-full, empty and almost-empty. The full pair is timed by the write clock and the empty pair by the read clock.

Each side works as a stream. `full_n` is the producer's ready: when it is high, a qualified write is accepted. `empty_n` is the consumer's valid: when it is high, a qualified read is accepted. A write made while `full_n` is low has no effect, and so does a read made while `empty_n` is low. Neither side has to wait for the other; it only has to look at its own flag. A dual-purpose pin, `wen2_ld`, is sampled while reset is held. If it is high, the block runs in dual-enable mode: the pin is a second write enable, used for depth expansion, and the almost-flags use fixed built-in offsets. If it is low, the block runs in programmable-flag mode: a low level on the pin marks offset-register traffic, and the almost-flags use the threshold values supplied on `empty_off` and `full_off`.

Top module: `xclk_fifo`

## Requirements
- R1: While `rst_n` is low (asynchronous), both pointers return to word 0 and `q` is cleared to 0. After reset, `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1.
- R2: The level of `wen2_ld` seen on write-clock edges while reset is low selects the mode: 1 gives dual-enable mode, 0 gives programmable-flag mode. Changing the pin after reset does not change the mode.
- R3: A word is stored on a rising `wclk` only when `wen1_n`=0 and `wen2_ld`=1. This holds in both modes. Any other combination stores nothing.
- R4: The output register loads the next word on a rising `rclk` only when `ren1_n`=0 and `ren2_n`=0. If either one is high, `q` holds its value.
- R5: Words are read out in exactly the order they were written, with no loss and no duplication.
- R6: After 256 unread words, `full_n` is 0. Writes made while `full_n` is 0 are discarded and overwrite nothing.
- R7: While `empty_n` is 0, reads are ignored and `q` holds its value.
- R8: `aempty_n` is 0 exactly when the number of words seen by the read side is at most the empty offset. The empty offset is `empty_off` in programmable-flag mode and 7 in dual-enable mode.
- R9: `afull_n` is 0 exactly when the free space seen by the write side is at most the full offset. The full offset is `full_off` in programmable-flag mode and 7 in dual-enable mode.
- R10: `q_oe` is 1 when `oe_n` is 0 and 0 when `oe_n` is 1. It stands in for the high-impedance control of `q`.
- R11: After a write into an empty FIFO, `empty_n` rises within 5 read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable or offset-load strobe, depending on mode |
| din | input | 9 | Write data |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| empty_off | input | 8 | Almost-empty threshold (programmable-flag mode) |
| full_off | input | 8 | Almost-full threshold (programmable-flag mode) |
| q | output | 9 | Registered read data |
| q_oe | output | 1 | Drive enable for `q`; 0 means high impedance |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| afull_n | output | 1 | Almost-full flag, active low, write-clock domain |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read-clock domain |

## Verification
A corrupted pointer or a wrong synchronized pointer shows up at `q` on the first read that follows it. The scoreboard then sees a word out of order, a repeated word, or a read that fires when no word is expected. A wrong level count shows up on the almost-flags at the threshold crossings, and these are probed one word on either side of the threshold. A mode bit that is latched wrongly shows up as an almost-empty flag that answers to the wrong offset, within a few read-clock cycles of the writes.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  typedef enum logic {
    WMODE_DUAL  = 1'b0,
    WMODE_PFLAG = 1'b1
  } wmode_e;
endpackage

// File: rtl/xcf_ram.sv
module xcf_ram #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xcf_ptr_xfer.sv
module xcf_ptr_xfer #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_bin,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] gray_src;
  logic [W-1:0] stg [STAGES];

  // Gray-coded copy, registered in the source domain
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_src <= '0;
    else        gray_src <= src_bin ^ (src_bin >> 1);
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n)      stg[s] <= '0;
      else if (s == 0) stg[s] <= gray_src;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    dst_bin[W-1] = stg[STAGES-1][W-1];
    for (int i = W-2; i >= 0; i--) dst_bin[i] = dst_bin[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DATA_W        = 9,
  parameter int ADDR_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int DEF_EMPTY_OFF = 7,
  parameter int DEF_FULL_OFF  = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic [DATA_W-1:0] din,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] empty_off,
  input  logic [ADDR_W-1:0] full_off,
  output logic [DATA_W-1:0] q,
  output logic              q_oe,
  output logic              full_n,
  output logic              afull_n,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  wmode_e            mode_q;
  logic [PTR_W-1:0]  wptr, rptr, rptr_w, wptr_r;
  logic [PTR_W-1:0]  wr_level, rd_level, wr_free;
  logic [ADDR_W-1:0] e_thr, f_thr;
  logic [DATA_W-1:0] ram_q, q_r;
  logic              wr_go, rd_go;

  // Mode strap: captured on write-clock edges while reset is held
  always_ff @(posedge wclk) begin
    if (!rst_n) mode_q <= wen2_ld ? WMODE_DUAL : WMODE_PFLAG;
  end

  assign e_thr = (mode_q == WMODE_PFLAG) ? empty_off : ADDR_W'(DEF_EMPTY_OFF);
  assign f_thr = (mode_q == WMODE_PFLAG) ? full_off  : ADDR_W'(DEF_FULL_OFF);

  // Write side
  assign wr_level = wptr - rptr_w;
  assign wr_free  = DEPTH_P - wr_level;
  assign full_n   = (wr_level != DEPTH_P);
  assign afull_n  = !(wr_free <= {1'b0, f_thr});
  assign wr_go    = rst_n && !wen1_n && wen2_ld && full_n;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)     wptr <= '0;
    else if (wr_go) wptr <= wptr + 1'b1;
  end

  // Read side
  assign rd_level = wptr_r - rptr;
  assign empty_n  = (rd_level != '0);
  assign aempty_n = !(rd_level <= {1'b0, e_thr});
  assign rd_go    = !ren1_n && !ren2_n && empty_n;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      q_r  <= '0;
    end else if (rd_go) begin
      rptr <= rptr + 1'b1;
      q_r  <= ram_q;
    end
  end

  assign q    = q_r;
  assign q_oe = !oe_n;

  xcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .clk  (wclk),
    .we   (wr_go),
    .waddr(wptr[ADDR_W-1:0]),
    .wdata(din),
    .raddr(rptr[ADDR_W-1:0]),
    .rdata(ram_q)
  );

  xcf_ptr_xfer #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n),
    .src_bin(wptr), .dst_bin(wptr_r)
  );

  xcf_ptr_xfer #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n),
    .src_bin(rptr), .dst_bin(rptr_w)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              ren1_n,
  input logic              ren2_n,
  input logic [DATA_W-1:0] q,
  input logic              empty_n,
  input logic              aempty_n,
  input logic              full_n,
  input logic              afull_n,
  input logic              mode_q,
  input logic [ADDR_W:0]   wr_level,
  input logic [ADDR_W:0]   rd_level
);
  localparam logic [ADDR_W:0] DEPTH_C = (ADDR_W+1)'(1 << ADDR_W);

  assert_mode_hold_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

  assert_hold_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n || ren2_n) |=> $stable(q));

  assert_no_overflow_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_level <= DEPTH_C);

  assert_empty_ignore_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(q));

  assert_no_underflow_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_level <= DEPTH_C);

  assert_empty_aempty_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  assert_full_afull_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk    (wclk),
  .rclk    (rclk),
  .rst_n   (rst_n),
  .ren1_n  (ren1_n),
  .ren2_n  (ren2_n),
  .q       (q),
  .empty_n (empty_n),
  .aempty_n(aempty_n),
  .full_n  (full_n),
  .afull_n (afull_n),
  .mode_q  (mode_q),
  .wr_level(wr_level),
  .rd_level(rd_level)
);

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW = 9;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          wen1_n = 1'b1, wen2_ld = 1'b0, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] empty_off = 8'd3, full_off = 8'd5;
  logic [DW-1:0] q;
  logic          q_oe, full_n, afull_n, empty_n, aempty_n;

  int            checks = 0, fails = 0, npop = 0;
  logic [DW-1:0] sb_q [$];
  bit            rd_pend = 1'b0;

  always #(CLK_PERIOD/2)  wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  xclk_fifo dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
    .empty_off(empty_off), .full_off(full_off), .q(q), .q_oe(q_oe),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Write-side monitor: records each word the producer offers while ready (R3, R6)
  always @(negedge wclk) begin
    if (rst_n && !wen1_n && wen2_ld && full_n) sb_q.push_back(din);
  end

  // Read-side monitor: compares the output with the scoreboard (R5, R7)
  always @(negedge rclk) begin
    if (rd_pend) begin
      npop++;
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 read with no word expected actual=%0d expected=none", q);
      end else begin
        check("R5 read order", q, sb_q.pop_front());
      end
    end
    rd_pend = rst_n && !ren1_n && !ren2_n && empty_n;
  end

  task automatic do_reset(bit strap);
    wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    wen2_ld = strap;
    rst_n = 1'b0;
    repeat (4) @(posedge wclk);
    @(negedge wclk);
    rst_n = 1'b1;
    sb_q.delete();
    rd_pend = 1'b0;
    @(posedge wclk); #1;
    wen2_ld = 1'b1;
  endtask

  task automatic write_words(int n, int base);
    for (int i = 0; i < n; i++) begin
      @(posedge wclk); #1;
      din = DW'(base + i * 37);
      wen1_n = 1'b0;
    end
    @(posedge wclk); #1;
    wen1_n = 1'b1;
  endtask

  task automatic drain();
    int guard = 0;
    @(posedge rclk); #1;
    ren1_n = 1'b0; ren2_n = 1'b0;
    while (sb_q.size() != 0 && guard < 3000) begin
      @(negedge rclk);
      guard++;
    end
    @(posedge rclk); #1;
    ren1_n = 1'b1; ren2_n = 1'b1;
    check("R5 all words returned", sb_q.size(), 0);
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    checks++; fails++;
    $display("FAIL watchdog on R1..R11 run actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    int pop0;
    // ---- programmable-flag mode, offsets 3 / 5
    do_reset(1'b0);
    @(negedge rclk);
    check("R1 q after reset", q, 0);
    check("R1 empty_n after reset", empty_n, 0);
    check("R1 aempty_n after reset", aempty_n, 0);
    check("R1 full_n after reset", full_n, 1);
    check("R1 afull_n after reset", afull_n, 1);

    oe_n = 1'b1; #1;
    check("R10 q_oe with oe_n high", q_oe, 0);
    oe_n = 1'b0; #1;
    check("R10 q_oe with oe_n low", q_oe, 1);

    // R7: reads while empty
    @(posedge rclk); #1;
    ren1_n = 1'b0; ren2_n = 1'b0;
    repeat (3) @(posedge rclk);
    #1; ren1_n = 1'b1; ren2_n = 1'b1;
    @(negedge rclk);
    check("R7 q held while empty", q, 0);

    // R3: non-qualifying write combinations
    @(posedge wclk); #1;
    din = 9'h1F0; wen1_n = 1'b1; wen2_ld = 1'b1;
    repeat (2) @(posedge wclk); #1;
    wen1_n = 1'b0; wen2_ld = 1'b0;
    repeat (2) @(posedge wclk); #1;
    wen1_n = 1'b1; wen2_ld = 1'b1;
    settle();
    check("R3 no store without both enables", empty_n, 0);

    // R11: empty flag latency
    write_words(1, 9'h0A5);
    lat = 0;
    while (!empty_n && lat < 10) begin
      @(negedge rclk);
      lat++;
    end
    check("R11 empty_n rise within 5 read cycles", int'(lat <= 5), 1);

    // R8: almost-empty around offset 3
    write_words(2, 9'h100);
    settle();
    check("R8 aempty_n at count 3, offset 3", aempty_n, 0);
    write_words(1, 9'h033);
    settle();
    check("R8 aempty_n at count 4, offset 3", aempty_n, 1);

    // R4: one read enable alone does nothing
    @(posedge rclk); #1;
    ren1_n = 1'b0; ren2_n = 1'b1;
    repeat (3) @(posedge rclk); #1;
    ren1_n = 1'b1; ren2_n = 1'b0;
    repeat (3) @(posedge rclk); #1;
    ren2_n = 1'b1;
    @(negedge rclk);
    check("R4 q held with single enable", q, 0);
    check("R4 words retained", sb_q.size(), 4);
    drain();
    settle();
    check("R7 empty_n after drain", empty_n, 0);

    // R6 / R9: fill to the top
    write_words(250, 9'h011);
    @(negedge wclk);
    check("R9 afull_n at free 6, offset 5", afull_n, 1);
    write_words(1, 9'h155);
    @(negedge wclk);
    check("R9 afull_n at free 5, offset 5", afull_n, 0);
    check("R6 full_n before last words", full_n, 1);
    write_words(5, 9'h0C0);
    @(negedge wclk);
    check("R6 full_n at 256 words", full_n, 0);
    write_words(4, 9'h1EE);
    pop0 = npop;
    drain();
    check("R6 exactly 256 words read back", npop - pop0, DEPTH);
    settle();
    check("R6 full_n after drain", full_n, 1);
    check("R9 afull_n after drain", afull_n, 1);
    check("R8 aempty_n after drain", aempty_n, 0);

    // ---- dual-enable mode: built-in offset 7, port offset ignored
    empty_off = 8'd0;
    do_reset(1'b1);
    @(negedge rclk);
    check("R1 q cleared by second reset", q, 0);
    write_words(7, 9'h070);
    settle();
    check("R2 dual mode uses offset 7 at count 7", aempty_n, 0);
    @(posedge wclk); #1;
    din = 9'h1AA; wen1_n = 1'b0; wen2_ld = 1'b0;
    @(posedge wclk); #1;
    wen1_n = 1'b1; wen2_ld = 1'b1;
    settle();
    check("R3 dual mode needs second enable high", aempty_n, 0);
    write_words(1, 9'h0F0);
    settle();
    check("R8 aempty_n at count 8, offset 7", aempty_n, 1);
    drain();

    // ---- back to programmable-flag mode with offset 0
    do_reset(1'b0);
    write_words(1, 9'h123);
    settle();
    check("R2 programmable mode uses port offset 0", aempty_n, 1);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule